// File: doc/BRIEF.md
# Two-Source Interrupt Level and Vector Responder

This block sits between two peripheral sections and the interrupt request lines of a processor. The two sections are a queued SPI section and an asynchronous serial (UART) section. Each section has its own programmable 3-bit request level. While a section requests, the block raises the matching line of a seven-line request bus. Only the highest active line is shown, so a lower request stays hidden until the higher one clears. The block holds no pending state: both request inputs are level-sensitive.

When the processor starts an interrupt-acknowledge cycle, it presents the level being acknowledged. The block contends only if that level equals the programmed level of a section that is requesting, and only if its arbitration ID is nonzero. Arbitration itself happens outside the block and comes back as a single grant input. After the grant, the block drives a vector byte for one cycle together with a valid strobe. Both sections share the upper seven vector bits. Bit 0 names the serviced section: 1 for SPI, 0 for UART.

The acknowledge controller has four named states:

- **IDLE**: waits for a qualifying acknowledge. It goes to CONTEND when the acknowledge is present, the level matches, and the ID is nonzero. It latches which section is serviced, and SPI wins a tie at the same level.
- **CONTEND**: goes to DRIVE when the grant arrives while the acknowledge is still held. It goes back to IDLE if the acknowledge drops first.
- **DRIVE**: asserts the valid strobe and the vector for this single cycle. It then goes to HOLD if the acknowledge is still present, or to IDLE if it is not.
- **HOLD**: waits for the acknowledge to drop, then goes to IDLE.

Top module: `irq_vec_responder`

## Requirements
- R1: Register 0 bits [2:0] hold the SPI level and bits [6:4] hold the UART level. A level n in 1..7 sets `irq_out[n-1]` (line IRQn) while that section requests.
- R2: A level of 0 disables a section. It raises no line, and an acknowledge cycle gets no response for it.
- R3: When both sections request at different nonzero levels, only the higher line is set. The lower line reappears when the higher request clears.
- R4: Request inputs are level-sensitive. When a section deasserts its request, its line drops in the same cycle, and with no requests `irq_out` is zero.
- R5: After reset, register 0 reads 0x00, register 1 (vector) reads 0x0F, and register 2 (arbitration ID, bits [3:0] used) reads 0x00.
- R6: A write to vector bit 0 is ignored, and reads of register 1 always return bit 0 as 1.
- R7: An acknowledge at a matching level, with a nonzero ID and the grant held, produces `vec_valid` for exactly one cycle. This happens two clock edges after acknowledge and grant are first sampled. `vec_out[7:1]` equals register 1 bits [7:1], and `vec_out[0]` is 1 for SPI and 0 for UART.
- R8: If both sections request at the same level and that level is acknowledged, the SPI section is serviced, so `vec_out[0]` = 1.
- R9: With an arbitration ID of 0, the block never responds to an acknowledge.
- R10: An acknowledge whose level matches no requesting section gets no response. `vec_out` is zero whenever `vec_valid` is low.
- R11: If the acknowledge drops before the grant, the cycle is abandoned. A grant with no acknowledge has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 8 | Register read data (combinational) |
| spi_req | input | 1 | SPI section request (level) |
| uart_req | input | 1 | UART section request (level) |
| irq_out | output | 7 | Request lines, bit n-1 is IRQn |
| ack_valid | input | 1 | Interrupt-acknowledge cycle in progress |
| ack_level | input | 3 | Level being acknowledged |
| arb_win | input | 1 | External arbitration granted to this block |
| vec_out | output | 8 | Vector byte, zero when not valid |
| vec_valid | output | 1 | One-cycle vector strobe |

## Verification
The bench builds the block with its default parameters: 3-bit levels giving seven lines, an 8-bit vector resetting to 0x0F, and a 4-bit arbitration ID. With these values, every line position, the top and bottom levels 7 and 1, and the disabled level 0 are all reachable. The same values allow both the same-level tie and the ID-zero case to be driven directly from the ports.

// File: rtl/irqv_pkg.sv
package irqv_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_CONTEND = 2'd1,
        ST_DRIVE   = 2'd2,
        ST_HOLD    = 2'd3
    } ack_state_t;

    localparam logic [1:0] ADDR_LEVELS = 2'd0;
    localparam logic [1:0] ADDR_VECTOR = 2'd1;
    localparam logic [1:0] ADDR_ARBID  = 2'd2;
endpackage

// File: rtl/irqv_regs.sv
module irqv_regs #(
    parameter int          LVL_W     = 3,
    parameter int          VEC_W     = 8,
    parameter int          ARB_W     = 4,
    parameter logic [7:0]  VEC_RESET = 8'h0F
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [7:0]       wr_data,
    input  logic [1:0]       rd_addr,
    output logic [7:0]       rd_data,
    output logic [LVL_W-1:0] spi_lvl,
    output logic [LVL_W-1:0] uart_lvl,
    output logic [VEC_W-1:1] vec_hi,
    output logic [ARB_W-1:0] arb_id
);
    import irqv_pkg::*;

    logic [7:0]       cfg_q;
    logic [VEC_W-1:1] vec_q;
    logic [ARB_W-1:0] id_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
            vec_q <= VEC_RESET[VEC_W-1:1];
            id_q  <= '0;
        end else if (wr_en) begin
            unique case (wr_addr)
                ADDR_LEVELS: cfg_q <= wr_data;
                ADDR_VECTOR: vec_q <= wr_data[VEC_W-1:1];
                ADDR_ARBID:  id_q  <= wr_data[ARB_W-1:0];
                default: ;
            endcase
        end
    end

    always_comb begin
        unique case (rd_addr)
            ADDR_LEVELS: rd_data = cfg_q;
            ADDR_VECTOR: rd_data = {vec_q, 1'b1};
            ADDR_ARBID:  rd_data = 8'(id_q);
            default:     rd_data = '0;
        endcase
    end

    assign spi_lvl  = cfg_q[LVL_W-1:0];
    assign uart_lvl = cfg_q[4+LVL_W-1:4];
    assign vec_hi   = vec_q;
    assign arb_id   = id_q;
endmodule

// File: rtl/irqv_line_map.sv
module irqv_line_map #(
    parameter int LVL_W = 3,
    localparam int NUM_LINES = (1 << LVL_W) - 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 spi_req,
    input  logic                 uart_req,
    input  logic [LVL_W-1:0]     spi_lvl,
    input  logic [LVL_W-1:0]     uart_lvl,
    output logic [NUM_LINES-1:0] irq_out
);
    logic [NUM_LINES-1:0] raw_lines;

    for (genvar n = 1; n <= NUM_LINES; n++) begin : g_line
        assign raw_lines[n-1] = (spi_req  && spi_lvl  == LVL_W'(n)) ||
                                (uart_req && uart_lvl == LVL_W'(n));
    end

    always_comb begin
        irq_out = '0;
        for (int i = 0; i < NUM_LINES; i++) begin
            if (raw_lines[i]) begin
                irq_out    = '0;
                irq_out[i] = 1'b1;
            end
        end
    end

    p_one_line_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(irq_out));
    p_no_req_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!spi_req && !uart_req) |-> (irq_out == '0));
endmodule

// File: rtl/irqv_ack_fsm.sv
module irqv_ack_fsm #(
    parameter int LVL_W = 3,
    parameter int VEC_W = 8,
    parameter int ARB_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             spi_req,
    input  logic             uart_req,
    input  logic [LVL_W-1:0] spi_lvl,
    input  logic [LVL_W-1:0] uart_lvl,
    input  logic [VEC_W-1:1] vec_hi,
    input  logic [ARB_W-1:0] arb_id,
    input  logic             ack_valid,
    input  logic [LVL_W-1:0] ack_level,
    input  logic             arb_win,
    output logic [VEC_W-1:0] vec_out,
    output logic             vec_valid
);
    import irqv_pkg::*;

    ack_state_t state_q, state_d;
    logic       src_spi_q, src_spi_d;
    logic       spi_hit, uart_hit, may_contend;

    assign spi_hit     = spi_req  && (spi_lvl  != '0) && (spi_lvl  == ack_level);
    assign uart_hit    = uart_req && (uart_lvl != '0) && (uart_lvl == ack_level);
    assign may_contend = ack_valid && (arb_id != '0) && (spi_hit || uart_hit);

    always_comb begin
        state_d   = state_q;
        src_spi_d = src_spi_q;
        unique case (state_q)
            ST_IDLE: if (may_contend) begin
                state_d   = ST_CONTEND;
                src_spi_d = spi_hit;
            end
            ST_CONTEND: begin
                if (!ack_valid)   state_d = ST_IDLE;
                else if (arb_win) state_d = ST_DRIVE;
            end
            ST_DRIVE: state_d = ack_valid ? ST_HOLD : ST_IDLE;
            ST_HOLD:  if (!ack_valid) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            src_spi_q <= 1'b0;
        end else begin
            state_q   <= state_d;
            src_spi_q <= src_spi_d;
        end
    end

    always_comb begin
        vec_valid = (state_q == ST_DRIVE);
        vec_out   = vec_valid ? {vec_hi, src_spi_q} : '0;
    end

    p_id_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && arb_id == '0) |=> (state_q != ST_CONTEND));
    p_level_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && ack_level == '0) |=> (state_q == ST_IDLE));
    p_drop_abandon_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CONTEND && !ack_valid) |=> (state_q == ST_IDLE));
endmodule

// File: rtl/irq_vec_responder.sv
module irq_vec_responder #(
    parameter int          LVL_W     = 3,
    parameter int          VEC_W     = 8,
    parameter int          ARB_W     = 4,
    parameter logic [7:0]  VEC_RESET = 8'h0F,
    localparam int         NUM_LINES = (1 << LVL_W) - 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [1:0]           wr_addr,
    input  logic [7:0]           wr_data,
    input  logic [1:0]           rd_addr,
    output logic [7:0]           rd_data,
    input  logic                 spi_req,
    input  logic                 uart_req,
    output logic [NUM_LINES-1:0] irq_out,
    input  logic                 ack_valid,
    input  logic [LVL_W-1:0]     ack_level,
    input  logic                 arb_win,
    output logic [VEC_W-1:0]     vec_out,
    output logic                 vec_valid
);
    logic [LVL_W-1:0] spi_lvl, uart_lvl;
    logic [VEC_W-1:1] vec_hi;
    logic [ARB_W-1:0] arb_id;

    irqv_regs #(.LVL_W(LVL_W), .VEC_W(VEC_W), .ARB_W(ARB_W), .VEC_RESET(VEC_RESET)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .spi_lvl(spi_lvl), .uart_lvl(uart_lvl),
        .vec_hi(vec_hi), .arb_id(arb_id)
    );

    irqv_line_map #(.LVL_W(LVL_W)) u_lines (
        .clk(clk), .rst_n(rst_n), .spi_req(spi_req), .uart_req(uart_req),
        .spi_lvl(spi_lvl), .uart_lvl(uart_lvl), .irq_out(irq_out)
    );

    irqv_ack_fsm #(.LVL_W(LVL_W), .VEC_W(VEC_W), .ARB_W(ARB_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .spi_req(spi_req), .uart_req(uart_req),
        .spi_lvl(spi_lvl), .uart_lvl(uart_lvl), .vec_hi(vec_hi), .arb_id(arb_id),
        .ack_valid(ack_valid), .ack_level(ack_level), .arb_win(arb_win),
        .vec_out(vec_out), .vec_valid(vec_valid)
    );

    p_single_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |=> !vec_valid);
    p_needs_grant_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vec_valid) |-> $past(arb_win && ack_valid));
    p_shared_bits_r7: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |-> (vec_out[VEC_W-1:1] == rd_data[VEC_W-1:1] || rd_addr != 2'd1));
    p_quiet_vector_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !vec_valid |-> (vec_out == '0));
endmodule

// File: tb/test_irq_vec_responder.sv
module test_irq_vec_responder;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [1:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       spi_req = 1'b0, uart_req = 1'b0;
    logic [6:0] irq_out;
    logic       ack_valid = 1'b0;
    logic [2:0] ack_level = '0;
    logic       arb_win = 1'b0;
    logic [7:0] vec_out;
    logic       vec_valid;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    irq_vec_responder i_irq_vec_responder (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .spi_req(spi_req), .uart_req(uart_req),
        .irq_out(irq_out), .ack_valid(ack_valid), .ack_level(ack_level),
        .arb_win(arb_win), .vec_out(vec_out), .vec_valid(vec_valid)
    );

    // [14:12] spi level, [11:9] uart level, [8] spi_req, [7] uart_req, [6:0] expected lines
    localparam int NV = 9;
    localparam logic [14:0] VECS [NV] = '{
        {3'd3, 3'd5, 1'b1, 1'b0, 7'h04},  // R1 spi at 3
        {3'd3, 3'd5, 1'b0, 1'b1, 7'h10},  // R1 uart at 5
        {3'd3, 3'd5, 1'b1, 1'b1, 7'h10},  // R3 higher wins
        {3'd7, 3'd1, 1'b1, 1'b1, 7'h40},  // R3 top level
        {3'd7, 3'd1, 1'b0, 1'b1, 7'h01},  // R1 bottom level
        {3'd0, 3'd2, 1'b1, 1'b1, 7'h02},  // R2 spi disabled
        {3'd0, 3'd0, 1'b1, 1'b1, 7'h00},  // R2 both disabled
        {3'd4, 3'd4, 1'b0, 1'b0, 7'h00},  // R4 no requests
        {3'd6, 3'd6, 1'b1, 1'b1, 7'h20}   // R8 shared level line
    };

    task automatic check(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_check(input logic [1:0] a, input logic [7:0] exp, input string req);
        rd_addr = a;
        #1;
        check(rd_data == exp, req, rd_data, exp);
    endtask

    // drives acknowledge (and optionally grant) for 4 cycles, counts strobes
    task automatic ack_seq(input logic [2:0] lvl, input bit grant, input int exp_n,
                           input logic [7:0] exp_v, input string req);
        int n = 0;
        int first = -1;
        bit quiet_ok = 1'b1;
        logic [7:0] got = '0;
        @(negedge clk);
        ack_valid = 1'b1; ack_level = lvl; arb_win = grant;
        for (int c = 1; c <= 4; c++) begin
            @(negedge clk);
            if (vec_valid) begin
                n++; got = vec_out;
                if (first < 0) first = c;
            end else if (vec_out != 8'h00) quiet_ok = 1'b0;
        end
        ack_valid = 1'b0; arb_win = 1'b0;
        @(negedge clk);
        check(n == exp_n, req, 8'(n), 8'(exp_n));
        if (exp_n > 0) begin
            check(got == exp_v, req, got, exp_v);
            check(first == 2, req, 8'(first), 8'd2);
        end
        check(quiet_ok, "R10 zero vector", 8'(quiet_ok), 8'd1);
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R5 reset state
        rd_check(2'd0, 8'h00, "R5 levels reset");
        rd_check(2'd1, 8'h0F, "R5 vector reset");
        rd_check(2'd2, 8'h00, "R5 id reset");
        check(irq_out == 7'h00, "R5 lines reset", 8'(irq_out), 8'h00);
        check(vec_valid == 1'b0, "R5 no strobe", 8'(vec_valid), 8'h00);

        for (int i = 0; i < NV; i++) begin
            wr(2'd0, {1'b0, VECS[i][11:9], 1'b0, VECS[i][14:12]});
            spi_req = VECS[i][8]; uart_req = VECS[i][7];
            #1;
            check(irq_out == VECS[i][6:0], "R1/R2/R3 table", 8'(irq_out), 8'(VECS[i][6:0]));
            @(negedge clk);
            spi_req = 1'b0; uart_req = 1'b0;
        end

        // R3 lower reappears, R4 same-cycle drop
        wr(2'd0, 8'h25);
        spi_req = 1'b1; uart_req = 1'b1;
        #1; check(irq_out == 7'h10, "R3 higher shown", 8'(irq_out), 8'h10);
        spi_req = 1'b0;
        #1; check(irq_out == 7'h02, "R3 lower reappears R4", 8'(irq_out), 8'h02);
        uart_req = 1'b0;
        #1; check(irq_out == 7'h00, "R4 drop", 8'(irq_out), 8'h00);

        // R6 bit 0 write ignored
        wr(2'd1, 8'h40);
        rd_check(2'd1, 8'h41, "R6 bit0 reads one");
        wr(2'd1, 8'hA4);
        rd_check(2'd1, 8'hA5, "R6 bit0 write ignored");

        // R9 id zero blocks response
        wr(2'd0, 8'h23);
        spi_req = 1'b1;
        ack_seq(3'd3, 1'b1, 0, 8'h00, "R9 id zero");
        wr(2'd2, 8'h05);
        rd_check(2'd2, 8'h05, "R9 id written");

        // R7 SPI response
        ack_seq(3'd3, 1'b1, 1, 8'hA5, "R7 spi vector");
        // R10 mismatched level
        ack_seq(3'd4, 1'b1, 0, 8'h00, "R10 level mismatch");
        // R7 UART response
        spi_req = 1'b0; uart_req = 1'b1;
        ack_seq(3'd2, 1'b1, 1, 8'hA4, "R7 uart vector");
        // R11 no grant, then grant without acknowledge
        ack_seq(3'd2, 1'b0, 0, 8'h00, "R11 no grant");
        @(negedge clk); arb_win = 1'b1;
        repeat (3) @(negedge clk);
        check(vec_valid == 1'b0, "R11 lone grant", 8'(vec_valid), 8'h00);
        arb_win = 1'b0;
        // R8 same-level tie
        wr(2'd0, 8'h66);
        spi_req = 1'b1; uart_req = 1'b1;
        ack_seq(3'd6, 1'b1, 1, 8'hA5, "R8 spi wins tie");
        // R2 disabled spi, level 0 acknowledge
        wr(2'd0, 8'h60);
        uart_req = 1'b0;
        ack_seq(3'd0, 1'b1, 0, 8'h00, "R2 level zero");
        spi_req = 1'b0;

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule